// File: doc/BRIEF.md
# Recirculating Shift-Line Digital Pulse Width Modulator

This block turns a 7-bit duty code into one pulse-width-modulated waveform per switching period. It runs on a fast clock that ticks exactly 128 times per period. Timing does not come from a 128-stage delay chain. A single token travels around a 16-stage shift line, and the last stage feeds back into the first, so the token makes eight laps. A window counter marks which lap is in progress. The PWM output is cleared by the first cycle in which the token sits on the chosen tap during the chosen lap.

A controller drives a one-cycle start pulse once per period, together with the tap index (the low four bits of the duty code) and the lap index (the high three bits). Both are captured on the start pulse. The same captured code also chooses between a small and a large power switch. Codes below one-quarter plus one-eighth of full scale select the small switch, which improves efficiency at light load.

Top module: `dpwm_recirc`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pwm` and `big_sw` are low. A run with no start pulse never raises `pwm`.
- R2: For a duty value d = 16*`pass_sel` + `tap_sel` with d > 0, `pwm` rises at the first clock edge after the edge that samples `start`.
- R3: `pwm` stays high for exactly d fast-clock cycles, then falls, for every d from 1 to 127.
- R4: For d = 0, `pwm` stays low for the whole period.
- R5: `tap_sel` and `pass_sel` are sampled only on the edge where `start` is high. Changes between start pulses do not alter the pulse width of the period in progress.
- R6: `big_sw` is high exactly when the captured d is at least 48 (binary 0110000). It takes its new value on the edge that samples `start` and holds it until the next start.
- R7: The token does not recirculate past 128 cycles. With no further start pulse, `pwm` stays low indefinitely after the period ends.
- R8: A start pulse during a period abandons the old token and begins a fresh period. `pwm` then falls exactly d cycles after the new start edge, using the newly captured code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, 128 ticks per switching period |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that opens a switching period |
| tap_sel | input | 4 | Tap index, low part of the duty code |
| pass_sel | input | 3 | Lap index, high part of the duty code |
| pwm | output | 1 | Pulse-width-modulated output |
| big_sw | output | 1 | High selects the large power switch, low the small one |

## Verification
The bench builds the block with its default 16 taps and 8 laps. With these values the whole 128-value duty space is swept, so every tap/lap pair, both ends of the range (0 and 127) and both sides of the switch threshold at 48 are checked. Each sweep period also scrambles the select inputs while the period is running. A long idle stretch after a period and a restart in the middle of a period complete the run.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    typedef enum logic {SW_SMALL = 1'b0, SW_LARGE = 1'b1} sw_size_t;

    // Duty value from lap index and tap index
    function automatic int unsigned duty_of(input int unsigned lap,
                                            input int unsigned tap,
                                            input int unsigned stages);
        return lap * stages + tap;
    endfunction

    function automatic sw_size_t size_for(input int unsigned duty,
                                          input int unsigned threshold);
        return (duty >= threshold) ? SW_LARGE : SW_SMALL;
    endfunction
endpackage

// File: rtl/dpwm_shift_line.sv
module dpwm_shift_line #(
    parameter int STAGES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              recirc_en,
    output logic [STAGES-1:0] line
);
    always_ff @(posedge clk) begin
        if (rst) line[0] <= 1'b0;
        else     line[0] <= launch | (recirc_en & line[STAGES-1]);
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || launch) line[i] <= 1'b0;
            else               line[i] <= line[i-1];
        end
    end

    // R7
    line_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(line));
endmodule

// File: rtl/dpwm_pass_timer.sv
module dpwm_pass_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             active,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) active <= 1'b0;
        end
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !start && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));
    // R7
    period_end_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !start && cnt == LAST) |=> !active);
endmodule

// File: rtl/dpwm_out_stage.sv
module dpwm_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic period_open,
    input  logic hit,
    output logic pwm
);
    always_ff @(posedge clk) begin
        if (rst)              pwm <= 1'b0;
        else if (hit)         pwm <= 1'b0;
        else if (period_open) pwm <= 1'b1;
    end

    // R3
    drop_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> !pwm);
    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> !pwm);
endmodule

// File: rtl/dpwm_recirc.sv
module dpwm_recirc #(
    parameter int TAP_W  = 4,
    parameter int PASS_W = 3,
    parameter int BIG_TH = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TAP_W-1:0]  tap_sel,
    input  logic [PASS_W-1:0] pass_sel,
    output logic              pwm,
    output logic              big_sw
);
    import dpwm_pkg::*;

    localparam int STAGES = 1 << TAP_W;
    localparam int CNT_W  = TAP_W + PASS_W;

    logic [TAP_W-1:0]  tap_q;
    logic [PASS_W-1:0] pass_q;
    logic [STAGES-1:0] line;
    logic [CNT_W-1:0]  cnt;
    logic              active;
    logic              recirc_en;
    logic              hit;
    logic              period_open;
    sw_size_t          sw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q  <= '0;
            pass_q <= '0;
            sw_q   <= SW_SMALL;
        end else if (start) begin
            tap_q  <= tap_sel;
            pass_q <= pass_sel;
            sw_q   <= size_for(duty_of(32'(pass_sel), 32'(tap_sel), STAGES), BIG_TH);
        end
    end

    assign big_sw      = (sw_q == SW_LARGE);
    assign recirc_en   = active && (cnt != {CNT_W{1'b1}});
    assign hit         = active && line[tap_q] && (cnt[CNT_W-1:TAP_W] == pass_q);
    assign period_open = active && (cnt == '0);

    dpwm_pass_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .start(start), .active(active), .cnt(cnt)
    );

    dpwm_shift_line #(.STAGES(STAGES)) u_line (
        .clk(clk), .rst(rst), .launch(start), .recirc_en(recirc_en), .line(line)
    );

    dpwm_out_stage u_out (
        .clk(clk), .rst(rst), .period_open(period_open), .hit(hit), .pwm(pwm)
    );

    // R5 R6
    sw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(big_sw));
    // R4
    zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (period_open && tap_q == '0 && pass_q == '0) |=> !pwm);
endmodule

// File: tb/dpwm_recirc_bench.sv
module dpwm_recirc_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] tap_sel = '0;
    logic [2:0] pass_sel = '0;
    logic       pwm;
    logic       big_sw;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dpwm_recirc u_dpwm_recirc (
        .clk(clk), .rst(rst), .start(start), .tap_sel(tap_sel),
        .pass_sel(pass_sel), .pwm(pwm), .big_sw(big_sw)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic launch(input int d);
        @(negedge clk);
        tap_sel  = 4'(d % 16);
        pass_sel = 3'(d / 16);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    // Runs a full period for duty d, scrambling the selects mid-period
    task automatic run_period(input int d);
        int width = 0;
        int first = -1;
        launch(d);
        check("R6 big_sw", big_sw, (d >= 48) ? 1 : 0);
        for (int k = 1; k <= 128; k++) begin
            @(negedge clk);
            if (k == 5) begin
                tap_sel  = 4'((d * 7 + 3) % 16);
                pass_sel = 3'((d + 5) % 8);
            end
            if (pwm) begin
                width++;
                if (first < 0) first = k;
            end
        end
        check("R3 R5 width", width, d);
        if (d > 0) check("R2 rise", first, 1);
        else       check("R4 zero duty", width, 0);
        check("R6 big_sw held", big_sw, (d >= 48) ? 1 : 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pwm in reset", pwm, 0);
        check("R1 big_sw in reset", big_sw, 0);
        rst = 1'b0;
        begin
            int hi = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (pwm) hi++;
            end
            check("R1 idle without start", hi, 0);
        end

        for (int d = 0; d < 128; d++) run_period(d);

        // R7: after a full-length period, no recirculated pulse
        run_period(127);
        begin
            int hi = 0;
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (pwm) hi++;
            end
            check("R7 no stray pulse", hi, 0);
        end

        // R8: restart in the middle of a period
        launch(100);
        repeat (19) @(negedge clk);
        launch(10);
        begin
            int width = 1;
            for (int k = 1; k <= 128; k++) begin
                @(negedge clk);
                if (k == 10) check("R8 high before new end", pwm, 1);
                if (k == 11) check("R8 low after new end", pwm, 0);
                if (k > 10 && pwm) width++;
            end
            check("R8 no pulse after restart end", width, 1);
        end
        check("R8 big_sw", big_sw, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule